// File: doc/BRIEF.md
# Three-Operand Logic and Shift Execute Unit

This block is the combinational execute stage for the three-register instruction class. It takes a 32-bit instruction word and two W-bit operand values, already read from the register file. It returns the W-bit value to be written to the destination register, together with a write enable. It also returns the three register-select nibbles, so the surrounding pipeline can address the register file without decoding the word a second time.

Within the class, the unit handles these functions:
- wrapping add and subtract;
- signed and unsigned maximum and minimum;
- ten bitwise Boolean functions, including the four implication and nonimplication forms;
- eight shifts and rotates, with a choice of arithmetic, zero, or ones fill.

Any other opcode in the class raises an unsupported flag and suppresses the write. This covers multiply, divide, packing, loads, stores and reserved codes. Words from any other class leave both flags low. No state is held: each output follows its inputs in the same cycle.

Decode proceeds in four steps, named by the unit-select enumeration:
1. The class byte is matched.
2. The extended opcode is split into an 8-bit group and a 4-bit function.
3. The group and the function's range choose one unit: `U_ADDSUB`, `U_MINMAX`, `U_BOOL` or `U_SHIFT`. When nothing matches, the choice is `U_NONE`.
4. A unit other than `U_NONE` commits the write. `U_NONE` inside the class signals unsupported.

Top module: `xop3_exec`

## Requirements
- R1: Field layout. The class is selected when `instr_i[31:24]` is 8'h05. The 12-bit extended opcode is `instr_i[23:12]`. The destination select is `instr_i[11:8]`, operand b is `instr_i[7:4]` and operand c is `instr_i[3:0]`. The three select outputs carry these nibbles for every word.
- R2: Opcodes 12'h000 (signed add) and 12'h001 (unsigned add) give b + c. Opcodes 12'h002 (signed subtract) and 12'h003 (unsigned subtract) give b - c. All four wrap modulo 2^W and assert `wr_en_o`.
- R3: Opcodes 12'h010 and 12'h011 give the larger of b and c, compared signed and unsigned respectively. Opcodes 12'h012 and 12'h013 give the smaller, signed and unsigned respectively.
- R4: Opcodes 12'h020 to 12'h025 give, in that order: b AND c, b OR c, b XOR c, NOT(b AND c), NOT(b OR c) and NOT(b XOR c).
- R5: Opcodes 12'h026 to 12'h029 give, in that order: (NOT b) AND c, b AND (NOT c), (NOT b) OR c, and b OR (NOT c).
- R6: Opcode 12'h032 shifts b left by c with zero fill, and opcode 12'h033 shifts b right by c with zero fill. Opcode 12'h030, the arithmetic left shift, gives exactly the zero-fill left result.
- R7: Opcode 12'h031 shifts b right by c and fills every vacated bit with b's most significant bit.
- R8: Opcodes 12'h034 and 12'h035 shift b left and right respectively by c, and fill every vacated bit with 1.
- R9: The shift amount is the full unsigned value of c. An amount of W or more makes the whole result fill bits: all zeros for zero fill, all ones for ones fill, and copies of b's sign for the arithmetic right shift.
- R10: Opcodes 12'h036 and 12'h037 rotate b left and right respectively by c modulo W. No bit is lost.
- R11: Inside the class, every other opcode asserts `unsup_o`, holds `wr_en_o` low and drives `result_o` to zero. This includes 12'h004 to 12'h00F, 12'h02A to 12'h02F, 12'h038 and above, and the reserved codes 12'h0E0 to 12'h0FF.
- R12: When `instr_i[31:24]` is not 8'h05, `wr_en_o` and `unsup_o` are both low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| opb_i | input | W | Value of the register selected by field b |
| opc_i | input | W | Value of the register selected by field c |
| dst_sel_o | output | 4 | Destination register select (field a) |
| srcb_sel_o | output | 4 | Operand b register select |
| srcc_sel_o | output | 4 | Operand c register select |
| result_o | output | W | Value to write to the destination register |
| wr_en_o | output | 1 | Write to the destination register |
| unsup_o | output | 1 | In-class opcode that this unit does not execute |

## Verification
Every arithmetic, compare and logic opcode is driven with operands whose answers differ between readings, so a swapped opcode gives a wrong result:
- The add and subtract cases cross the sign and carry boundaries.
- The max and min cases use an operand pair in which the signed and unsigned orders disagree (all ones against one).
- The Boolean functions use two masks with all four bit combinations present, so each truth table is pinned down.

For the shifter, the operands are chosen to expose specific faults:
- A sign-set operand separates the arithmetic right shift from the zero-fill right shift.
- An all-zero operand exposes the ones fill.
- Amounts of 0, 31, exactly W and far beyond W probe the saturation rule.
- Rotate amounts of W and W+4 separate modulo wrapping from saturation.

Reserved, out-of-scope and foreign-class words confirm that the write is suppressed and the flags are exclusive. A word with distinct a, b and c nibbles checks the field positions.

// File: rtl/xop3_pkg.sv
package xop3_pkg;

    localparam logic [7:0] CLASS_BYTE = 8'h05;

    // unit chosen by the extended-opcode group
    typedef enum logic [2:0] {
        U_NONE   = 3'd0,
        U_ADDSUB = 3'd1,
        U_MINMAX = 3'd2,
        U_BOOL   = 3'd3,
        U_SHIFT  = 3'd4
    } unit_e;

    // function codes (low nibble of the extended opcode)
    localparam logic [3:0] F_ADD   = 4'h0;
    localparam logic [3:0] F_ADDU  = 4'h1;
    localparam logic [3:0] F_SUB   = 4'h2;
    localparam logic [3:0] F_SUBU  = 4'h3;

    localparam logic [3:0] F_MAX   = 4'h0;
    localparam logic [3:0] F_MAXU  = 4'h1;
    localparam logic [3:0] F_MIN   = 4'h2;
    localparam logic [3:0] F_MINU  = 4'h3;

    localparam logic [3:0] F_AND   = 4'h0;
    localparam logic [3:0] F_OR    = 4'h1;
    localparam logic [3:0] F_XOR   = 4'h2;
    localparam logic [3:0] F_NAND  = 4'h3;
    localparam logic [3:0] F_NOR   = 4'h4;
    localparam logic [3:0] F_XNOR  = 4'h5;
    localparam logic [3:0] F_CNIMP = 4'h6;
    localparam logic [3:0] F_MNIMP = 4'h7;
    localparam logic [3:0] F_MIMP  = 4'h8;
    localparam logic [3:0] F_CIMP  = 4'h9;

    localparam logic [3:0] F_SAL   = 4'h0;
    localparam logic [3:0] F_SAR   = 4'h1;
    localparam logic [3:0] F_SL0   = 4'h2;
    localparam logic [3:0] F_SR0   = 4'h3;
    localparam logic [3:0] F_SL1   = 4'h4;
    localparam logic [3:0] F_SR1   = 4'h5;
    localparam logic [3:0] F_ROL   = 4'h6;
    localparam logic [3:0] F_ROR   = 4'h7;

    typedef struct packed {
        logic       hit;   // class byte matched
        unit_e      unit;  // selected unit, U_NONE when unsupported
        logic [3:0] fn;    // function within the unit
    } dec_t;

endpackage

// File: rtl/xop3_decode.sv
module xop3_decode
    import xop3_pkg::*;
(
    input  logic [31:0] instr_i,
    output dec_t        dec_o,
    output logic [3:0]  dst_sel_o,
    output logic [3:0]  srcb_sel_o,
    output logic [3:0]  srcc_sel_o
);

    logic [7:0] grp;
    logic [3:0] fn;

    assign grp        = instr_i[23:16];
    assign fn         = instr_i[15:12];
    assign dst_sel_o  = instr_i[11:8];
    assign srcb_sel_o = instr_i[7:4];
    assign srcc_sel_o = instr_i[3:0];

    always_comb begin
        dec_o.hit  = (instr_i[31:24] == CLASS_BYTE);
        dec_o.fn   = fn;
        dec_o.unit = U_NONE;
        if (dec_o.hit) begin
            unique case (grp)
                8'h00:   dec_o.unit = (fn <= 4'h3) ? U_ADDSUB : U_NONE;
                8'h01:   dec_o.unit = (fn <= 4'h3) ? U_MINMAX : U_NONE;
                8'h02:   dec_o.unit = (fn <= 4'h9) ? U_BOOL   : U_NONE;
                8'h03:   dec_o.unit = (fn <= 4'h7) ? U_SHIFT  : U_NONE;
                default: dec_o.unit = U_NONE;
            endcase
        end
    end

endmodule

// File: rtl/xop3_arith.sv
module xop3_arith
    import xop3_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         minmax_i,  // 0: add/sub group, 1: max/min group
    input  logic [1:0]   fn_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] y_o
);

    logic [W-1:0] sum;
    logic [W-1:0] dif;
    logic         s_gt;
    logic         u_gt;

    assign sum  = b_i + c_i;
    assign dif  = b_i - c_i;
    assign s_gt = ($signed(b_i) > $signed(c_i));
    assign u_gt = (b_i > c_i);

    always_comb begin
        y_o = '0;
        if (!minmax_i) begin
            unique case ({2'b00, fn_i})
                F_ADD, F_ADDU: y_o = sum;
                F_SUB, F_SUBU: y_o = dif;
                default:       y_o = '0;
            endcase
        end else begin
            unique case ({2'b00, fn_i})
                F_MAX:   y_o = s_gt ? b_i : c_i;
                F_MAXU:  y_o = u_gt ? b_i : c_i;
                F_MIN:   y_o = s_gt ? c_i : b_i;
                F_MINU:  y_o = u_gt ? c_i : b_i;
                default: y_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/xop3_bool.sv
module xop3_bool
    import xop3_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   fn_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] y_o
);

    always_comb begin
        unique case (fn_i)
            F_AND:   y_o = b_i & c_i;
            F_OR:    y_o = b_i | c_i;
            F_XOR:   y_o = b_i ^ c_i;
            F_NAND:  y_o = ~(b_i & c_i);
            F_NOR:   y_o = ~(b_i | c_i);
            F_XNOR:  y_o = ~(b_i ^ c_i);
            F_CNIMP: y_o = ~b_i & c_i;
            F_MNIMP: y_o = b_i & ~c_i;
            F_MIMP:  y_o = ~b_i | c_i;
            F_CIMP:  y_o = b_i | ~c_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/xop3_shift.sv
module xop3_shift
    import xop3_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   fn_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] y_o
);

    localparam int           SHW    = (W > 1) ? $clog2(W) : 1;
    localparam logic [W-1:0] W_V    = W'(W);
    localparam bit           POW2_W = ((W & (W - 1)) == 0);

    logic           big;       // amount saturates every bit
    logic [SHW-1:0] sh;        // in-range shift amount
    logic [SHW-1:0] rot;       // rotate amount modulo W
    logic [2*W-1:0] dbl_l;
    logic [2*W-1:0] dbl_r;
    logic [W-1:0]   sl0;
    logic [W-1:0]   sr0;
    logic [W-1:0]   sar;
    logic [W-1:0]   sl1;
    logic [W-1:0]   sr1;

    assign big = (c_i >= W_V);
    assign sh  = c_i[SHW-1:0];

    generate
        if (POW2_W) begin : g_rot_pow2
            assign rot = c_i[SHW-1:0];
        end else begin : g_rot_mod
            logic [W-1:0] rmod;
            assign rmod = c_i % W_V;
            assign rot  = rmod[SHW-1:0];
        end
    endgenerate

    assign sl0   = big ? '0 : (b_i << sh);
    assign sr0   = big ? '0 : (b_i >> sh);
    assign sar   = big ? {W{b_i[W-1]}} : W'($signed(b_i) >>> sh);
    assign sl1   = big ? '1 : ~((~b_i) << sh);
    assign sr1   = big ? '1 : ~((~b_i) >> sh);
    assign dbl_l = {b_i, b_i} << rot;
    assign dbl_r = {b_i, b_i} >> rot;

    always_comb begin
        unique case (fn_i)
            F_SAL, F_SL0: y_o = sl0;
            F_SAR:        y_o = sar;
            F_SR0:        y_o = sr0;
            F_SL1:        y_o = sl1;
            F_SR1:        y_o = sr1;
            F_ROL:        y_o = dbl_l[2*W-1:W];
            F_ROR:        y_o = dbl_r[W-1:0];
            default:      y_o = '0;
        endcase
    end

endmodule

// File: rtl/xop3_exec.sv
module xop3_exec
    import xop3_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [31:0]  instr_i,
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] opc_i,
    output logic [3:0]   dst_sel_o,
    output logic [3:0]   srcb_sel_o,
    output logic [3:0]   srcc_sel_o,
    output logic [W-1:0] result_o,
    output logic         wr_en_o,
    output logic         unsup_o
);

    dec_t         dec;
    logic [W-1:0] y_arith;
    logic [W-1:0] y_bool;
    logic [W-1:0] y_shift;

    xop3_decode u_dec (
        .instr_i    (instr_i),
        .dec_o      (dec),
        .dst_sel_o  (dst_sel_o),
        .srcb_sel_o (srcb_sel_o),
        .srcc_sel_o (srcc_sel_o)
    );

    xop3_arith #(.W(W)) u_arith (
        .minmax_i (dec.unit == U_MINMAX),
        .fn_i     (dec.fn[1:0]),
        .b_i      (opb_i),
        .c_i      (opc_i),
        .y_o      (y_arith)
    );

    xop3_bool #(.W(W)) u_bool (
        .fn_i (dec.fn),
        .b_i  (opb_i),
        .c_i  (opc_i),
        .y_o  (y_bool)
    );

    xop3_shift #(.W(W)) u_shift (
        .fn_i (dec.fn),
        .b_i  (opb_i),
        .c_i  (opc_i),
        .y_o  (y_shift)
    );

    always_comb begin
        result_o = '0;
        wr_en_o  = 1'b0;
        unsup_o  = 1'b0;
        unique case (dec.unit)
            U_ADDSUB, U_MINMAX: begin
                result_o = y_arith;
                wr_en_o  = 1'b1;
            end
            U_BOOL: begin
                result_o = y_bool;
                wr_en_o  = 1'b1;
            end
            U_SHIFT: begin
                result_o = y_shift;
                wr_en_o  = 1'b1;
            end
            default: unsup_o = dec.hit;
        endcase
    end

endmodule

// File: rtl/xop3_exec_chk.sv
module xop3_exec_chk #(
    parameter int W = 32
) (
    input logic [31:12] instr_i,
    input logic [W-1:0] opb_i,
    input logic [W-1:0] opc_i,
    input logic [W-1:0] result_o,
    input logic         wr_en_o,
    input logic         unsup_o
);

    localparam logic [W-1:0] W_V = W'(W);

    logic        in_cls;
    logic [11:0] xop;

    assign in_cls = (instr_i[31:24] == 8'h05);
    assign xop    = instr_i[23:12];

    always_comb begin
        // R11: write and unsupported flag never together
        p_flags_excl_r11: assert (!(wr_en_o && unsup_o));
        // R11: unsupported opcode writes nothing and yields zero
        p_unsup_zero_r11: assert (!unsup_o || (result_o == '0));
        // R12: a foreign class raises no flag
        p_foreign_quiet_r12: assert (in_cls || (!wr_en_o && !unsup_o && result_o == '0));
        // R3: unsigned max is never below either operand
        p_umax_bound_r3: assert (!(in_cls && xop == 12'h011) || (result_o >= opb_i && result_o >= opc_i));
        // R10: rotation keeps the number of set bits
        p_rot_keeps_bits_r10: assert (!(in_cls && (xop == 12'h036 || xop == 12'h037))
                                      || ($countones(result_o) == $countones(opb_i)));
        // R9: ones-fill shift by W or more is all ones
        p_ones_sat_r9: assert (!(in_cls && (xop == 12'h034 || xop == 12'h035) && opc_i >= W_V)
                               || (result_o == '1));
    end

endmodule

bind xop3_exec xop3_exec_chk #(.W(W)) u_chk (
    .instr_i  (instr_i[31:12]),
    .opb_i    (opb_i),
    .opc_i    (opc_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .unsup_o  (unsup_o)
);

// File: tb/xop3_exec_tb.sv
module xop3_exec_tb;

    localparam int W = 32;

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] exp;
        logic        we;
        logic        un;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VEC [NV] = '{
        '{32'h05000123, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 1'b0, 4'd2},  // R2 add over sign
        '{32'h05001123, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 1'b1, 1'b0, 4'd2},  // R2 addu wrap
        '{32'h05002123, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b1, 1'b0, 4'd2},  // R2 sub
        '{32'h05003123, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd2},  // R2 subu wrap
        '{32'h05010123, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b1, 1'b0, 4'd3},  // R3 max
        '{32'h05011123, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd3},  // R3 maxu
        '{32'h05012123, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd3},  // R3 min
        '{32'h05013123, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b1, 1'b0, 4'd3},  // R3 minu
        '{32'h05020123, 32'hF0F000FF, 32'hFF000F0F, 32'hF000000F, 1'b1, 1'b0, 4'd4},  // R4 and
        '{32'h05021123, 32'hF0F000FF, 32'hFF000F0F, 32'hFFF00FFF, 1'b1, 1'b0, 4'd4},  // R4 or
        '{32'h05022123, 32'hF0F000FF, 32'hFF000F0F, 32'h0FF00FF0, 1'b1, 1'b0, 4'd4},  // R4 xor
        '{32'h05023123, 32'hF0F000FF, 32'hFF000F0F, 32'h0FFFFFF0, 1'b1, 1'b0, 4'd4},  // R4 nand
        '{32'h05024123, 32'hF0F000FF, 32'hFF000F0F, 32'h000FF000, 1'b1, 1'b0, 4'd4},  // R4 nor
        '{32'h05025123, 32'hF0F000FF, 32'hFF000F0F, 32'hF00FF00F, 1'b1, 1'b0, 4'd4},  // R4 xnor
        '{32'h05026123, 32'h0000000C, 32'h0000000A, 32'h00000002, 1'b1, 1'b0, 4'd5},  // R5 ~b&c
        '{32'h05027123, 32'h0000000C, 32'h0000000A, 32'h00000004, 1'b1, 1'b0, 4'd5},  // R5 b&~c
        '{32'h05028123, 32'h0000000C, 32'h0000000A, 32'hFFFFFFFB, 1'b1, 1'b0, 4'd5},  // R5 ~b|c
        '{32'h05029123, 32'h0000000C, 32'h0000000A, 32'hFFFFFFFD, 1'b1, 1'b0, 4'd5},  // R5 b|~c
        '{32'h05030123, 32'h80000001, 32'h00000004, 32'h00000010, 1'b1, 1'b0, 4'd6},  // R6 sal = sl0
        '{32'h05031123, 32'h80000010, 32'h00000004, 32'hF8000001, 1'b1, 1'b0, 4'd7},  // R7 sar negative
        '{32'h05031123, 32'h40000000, 32'h00000004, 32'h04000000, 1'b1, 1'b0, 4'd7},  // R7 sar positive
        '{32'h05032123, 32'h000000FF, 32'h00000008, 32'h0000FF00, 1'b1, 1'b0, 4'd6},  // R6 sl0
        '{32'h05033123, 32'h80000000, 32'h0000001F, 32'h00000001, 1'b1, 1'b0, 4'd6},  // R6 sr0 by 31
        '{32'h05034123, 32'h00000000, 32'h00000004, 32'h0000000F, 1'b1, 1'b0, 4'd8},  // R8 sl1
        '{32'h05035123, 32'h00000000, 32'h00000004, 32'hF0000000, 1'b1, 1'b0, 4'd8},  // R8 sr1
        '{32'h05034123, 32'h00000000, 32'h00000020, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd9},  // R9 sl1 by W
        '{32'h05033123, 32'hFFFFFFFF, 32'h00000020, 32'h00000000, 1'b1, 1'b0, 4'd9},  // R9 sr0 by W
        '{32'h05031123, 32'h80000000, 32'h00000064, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd9},  // R9 sar by 100
        '{32'h05031123, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 4'd9},  // R9 sar by max
        '{32'h05032123, 32'h12345678, 32'h00000000, 32'h12345678, 1'b1, 1'b0, 4'd6},  // R6 shift by 0
        '{32'h05036123, 32'h80000001, 32'h00000004, 32'h00000018, 1'b1, 1'b0, 4'd10}, // R10 rol
        '{32'h05037123, 32'h80000001, 32'h00000004, 32'h18000000, 1'b1, 1'b0, 4'd10}, // R10 ror
        '{32'h05036123, 32'h80000001, 32'h00000024, 32'h00000018, 1'b1, 1'b0, 4'd10}, // R10 rol by W+4
        '{32'h05037123, 32'h80000001, 32'h00000020, 32'h80000001, 1'b1, 1'b0, 4'd10}, // R10 ror by W
        '{32'h0502A123, 32'h0000000C, 32'h0000000A, 32'h00000000, 1'b0, 1'b1, 4'd11}, // R11 reserved 02A
        '{32'h050E0123, 32'h0000000C, 32'h0000000A, 32'h00000000, 1'b0, 1'b1, 4'd11}, // R11 reserved 0E0
        '{32'h05006123, 32'h00000003, 32'h00000004, 32'h00000000, 1'b0, 1'b1, 4'd11}, // R11 multiply
        '{32'h05038123, 32'h00000003, 32'h00000004, 32'h00000000, 1'b0, 1'b1, 4'd11}, // R11 load
        '{32'h09000012, 32'h00000003, 32'h00000004, 32'h00000000, 1'b0, 1'b0, 4'd12}, // R12 other class
        '{32'h00000000, 32'h00000003, 32'h00000004, 32'h00000000, 1'b0, 1'b0, 4'd12}  // R12 zero word
    };

    logic          clk;
    logic          rst_n;
    logic [31:0]   instr;
    logic [W-1:0]  opb;
    logic [W-1:0]  opc;
    logic [3:0]    dst_sel;
    logic [3:0]    srcb_sel;
    logic [3:0]    srcc_sel;
    logic [W-1:0]  result;
    logic          wr_en;
    logic          unsup;

    int n_chk;
    int n_fail;
    bit done;

    xop3_exec #(.W(W)) u_dut (
        .instr_i    (instr),
        .opb_i      (opb),
        .opc_i      (opc),
        .dst_sel_o  (dst_sel),
        .srcb_sel_o (srcb_sel),
        .srcc_sel_o (srcc_sel),
        .result_o   (result),
        .wr_en_o    (wr_en),
        .unsup_o    (unsup)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [W-1:0] b, input logic [W-1:0] c);
        @(negedge clk);
        instr = ins;
        opb   = b;
        opc   = c;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        finish_run();
    end

    initial begin
        n_chk  = 0;
        n_fail = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        instr  = 32'h0;
        opb    = '0;
        opc    = '0;
        repeat (3) @(posedge clk);
        #1;
        // R12: state during reset, zero word is not in the class
        check("R12 reset wr_en", {63'd0, wr_en}, 64'd0);
        check("R12 reset unsup", {63'd0, unsup}, 64'd0);
        check("R12 reset result", {32'd0, result}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].ins, VEC[i].b, VEC[i].c);
            check($sformatf("R%0d vec %0d result", VEC[i].rq, i), {32'd0, result}, {32'd0, VEC[i].exp});
            check($sformatf("R%0d vec %0d wr_en", VEC[i].rq, i), {63'd0, wr_en}, {63'd0, VEC[i].we});
            check($sformatf("R%0d vec %0d unsup", VEC[i].rq, i), {63'd0, unsup}, {63'd0, VEC[i].un});
        end

        // R1: distinct a, b, c nibbles land on the select outputs
        apply(32'h05020A5F, 32'h0000FFFF, 32'h00FF00FF);
        check("R1 dst select", {60'd0, dst_sel}, 64'hA);
        check("R1 srcb select", {60'd0, srcb_sel}, 64'h5);
        check("R1 srcc select", {60'd0, srcc_sel}, 64'hF);
        check("R1 result", {32'd0, result}, 64'h000000FF);

        // R1: selects still follow the word for a foreign class
        apply(32'h1234_5678, 32'h1, 32'h2);
        check("R1 foreign dst select", {60'd0, dst_sel}, 64'h6);
        check("R1 foreign srcb select", {60'd0, srcb_sel}, 64'h7);

        // R11: last function past the shift group and end of reserved range
        apply(32'h0503F123, 32'h1, 32'h1);
        check("R11 xop 03F unsup", {63'd0, unsup}, 64'd1);
        apply(32'h050FF123, 32'h1, 32'h1);
        check("R11 xop 0FF unsup", {63'd0, unsup}, 64'd1);
        check("R11 xop 0FF wr_en", {63'd0, wr_en}, 64'd0);
        apply(32'h05004123, 32'h1, 32'h1);
        check("R11 xop 004 unsup", {63'd0, unsup}, 64'd1);

        // R6: arithmetic left equals zero-fill left for a sign-set operand
        apply(32'h05030123, 32'hC0000003, 32'h00000001);
        check("R6 sal sign operand", {32'd0, result}, 64'h80000006);
        // R7: sar by 31 of negative is all ones
        apply(32'h05031123, 32'h80000000, 32'h0000001F);
        check("R7 sar by 31", {32'd0, result}, 64'hFFFFFFFF);
        // R8: ones fill right by 31 keeps only bit 0 from b
        apply(32'h05035123, 32'h00000000, 32'h0000001F);
        check("R8 sr1 by 31", {32'd0, result}, 64'hFFFFFFFE);

        finish_run();
    end

endmodule